// File: doc/BRIEF.md
# Parallel EEPROM Byte Write Sequencer With Completion Polling

This block sits on the host side of a byte-wide parallel EEPROM with an 11-bit address and drives its active-low chip-enable, output-enable and write-enable strobes. A request stream carries one operation per beat: a read of one byte, or a write of one byte. For a write, the block spaces the strobes, address and data to the memory's minimum setup, pulse and hold times. It then waits for the memory's self-timed programming to finish and reports the outcome on a response stream. Every minimum time is a nanosecond parameter that is turned into a clock-cycle count by rounding up against a clock-period parameter. The counts quoted below assume the default 10 ns period.

Completion is detected in one of two ways, chosen per request by `wait_mode`. In the first, the block re-reads the written address until bit 7 of the returned byte equals bit 7 of the byte written. In the second, it watches the wired ready/busy line. In both ways a bounded timeout turns a write that never completes into an error. When completion is seen, a last full-byte read checks all eight bits, and a mismatch is reported as an error. The tristate data bus is split into an output value, an output enable and an input value; the pad lives outside the block.

Back-pressure: a request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so exactly one operation is outstanding. When `wait_mode` is 1, `req_ready` also stays low while the ready/busy line is low. A response is offered with `rsp_valid` and is held, with `rsp_data` and `rsp_err` unchanged, until a clock edge where `rsp_ready` is high. No new request is taken before then.

Top module: `nvm_byte_ctrl`

## Requirements
- R1: While reset is held, chip enable, output enable and write enable are high, the data bus is not driven and `rsp_valid` is low. After reset, `req_ready` is high when `wait_mode` is 0.
- R2: `req_ready` is low from the accepted request until its response is taken. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_data` and `rsp_err` hold their values.
- R3: A write holds chip enable low, output enable high, and the address and data driven for exactly 2 cycles before write enable falls. Write enable then stays low for exactly 15 cycles (the larger of the pulse width and the data setup time). The address and data stay at the requested values throughout.
- R4: After write enable rises, the address and data stay driven and unchanged, with output enable high, for exactly 2 more cycles.
- R5: The data bus is never driven while output enable is low. At least one cycle with the bus released and output enable high comes between driving the bus and any read.
- R6: Every read holds chip enable and output enable low for exactly 20 cycles and samples the data at the end of that window. A read request returns the byte stored at its address with `rsp_err` 0.
- R7: With `wait_mode` 0, after a write the block reads the written address repeatedly, with a released cycle between reads. It stops once a read returns bit 7 equal to bit 7 of the written byte.
- R8: With `wait_mode` 1, no read is issued while the ready/busy line is low. The only read of a successful write is the confirming read. After the response, `req_ready` stays low until the line is high.
- R9: If completion is not seen within the timeout (`T_WC_MAX_NS` rounded up to cycles, counted from the end of the write pulse hold), the response carries `rsp_err` 1 and no confirming read is made.
- R10: After completion, a full read of the written address is returned in `rsp_data`, with `rsp_err` 1 exactly when it differs from the written byte.
- R11: Write enable is never low while output enable is low or chip enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_mode | input | 1 | Completion method: 0 bit-7 polling, 1 ready/busy line |
| req_valid | input | 1 | Request beat valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 11 | Byte address |
| req_data | input | 8 | Byte to write |
| rsp_valid | output | 1 | Response beat valid |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | 8 | Byte read (confirming read for a write) |
| rsp_err | output | 1 | Timeout or confirm mismatch |
| mem_addr | output | 11 | Memory address |
| mem_dq_out | output | 8 | Data value for the bus pad |
| mem_dq_oe | output | 1 | Pad output enable |
| mem_dq_in | input | 8 | Data read from the bus pad |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_rdy_n | input | 1 | Wired ready/busy line, low while busy |

## Verification
The bench runs against a behavioural memory that returns the complement of bit 7 for the last written address while busy. It measures setup, pulse, hold and read windows cycle by cycle. A design off by one in any phase count shows a wrong window length, and one that drives the bus into an active read shows contention. Writes in polling mode are given both bit-7 polarities, which catches a design that compares against the polled value rather than the written value and so finishes at once or never. A memory that stores a byte differing only in bit 0 must raise the confirm error. Without the confirming read, the design would report success. Writes that stay busy beyond the timeout must report an error in both modes. In ready/busy mode the bench also checks that the next request is refused until the line releases; a design without that gate would start a write on a busy part.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_TURN,
    ST_PREAD,
    ST_PGAP,
    ST_RBDLY,
    ST_RBWAIT,
    ST_CREAD,
    ST_RREAD,
    ST_RESP
  } seq_state_t;

  // nanoseconds to whole clock cycles, rounded up
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nvm_cnt.sv
// Loadable down counter: a phase lasting N cycles loads N-1 on entry
// and ends in the cycle where zero is high.
module nvm_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/nvm_poll_cmp.sv
// Compares a sampled byte with the byte that was written.
module nvm_poll_cmp #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] sample,
  input  logic [DW-1:0] written,
  output logic          top_hit,
  output logic          all_hit
);

  assign top_hit = (sample[DW-1] == written[DW-1]);
  assign all_hit = (sample == written);

endmodule

// File: rtl/nvm_byte_ctrl.sv
module nvm_byte_ctrl
  import nvm_seq_pkg::*;
#(
  parameter int AW           = 11,
  parameter int DW           = 8,
  parameter int CLK_NS       = 10,
  parameter int T_AS_NS      = 10,
  parameter int T_AH_NS      = 100,
  parameter int T_WP_NS      = 150,
  parameter int T_DS_NS      = 50,
  parameter int T_DH_NS      = 10,
  parameter int T_OES_NS     = 15,
  parameter int T_OEH_NS     = 15,
  parameter int T_ACC_NS     = 200,
  parameter int T_OE_NS      = 80,
  parameter int T_DB_NS      = 80,
  parameter int T_WC_MAX_NS  = 10000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wait_mode,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_err,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  input  logic          mem_rdy_n
);

  localparam int unsigned PER    = int'(CLK_NS);
  localparam int unsigned AS_C   = ns_to_cyc(T_AS_NS, PER);
  localparam int unsigned AH_C   = ns_to_cyc(T_AH_NS, PER);
  localparam int unsigned WPR_C  = ns_to_cyc(T_WP_NS, PER);
  localparam int unsigned DS_C   = ns_to_cyc(T_DS_NS, PER);
  localparam int unsigned DH_C   = ns_to_cyc(T_DH_NS, PER);
  localparam int unsigned OES_C  = ns_to_cyc(T_OES_NS, PER);
  localparam int unsigned OEH_C  = ns_to_cyc(T_OEH_NS, PER);
  localparam int unsigned ACR_C  = ns_to_cyc(T_ACC_NS, PER);
  localparam int unsigned OER_C  = ns_to_cyc(T_OE_NS, PER);
  localparam int unsigned DBR_C  = ns_to_cyc(T_DB_NS, PER);
  localparam int unsigned TOR_C  = ns_to_cyc(T_WC_MAX_NS, PER);

  localparam int unsigned SU_C   = umax(1, umax(AS_C, OES_C));
  localparam int unsigned WP_C   = umax(1, umax(WPR_C, DS_C));
  localparam int unsigned AHX_C  = (AH_C > WP_C) ? AH_C - WP_C : 0;
  localparam int unsigned HOLD_C = umax(1, umax(AHX_C, umax(DH_C, OEH_C)));
  localparam int unsigned ACC_C  = umax(1, umax(ACR_C, OER_C));
  localparam int unsigned DB_C   = umax(1, DBR_C);
  localparam int unsigned TO_C   = umax(1, TOR_C);
  localparam int unsigned PH_MAX = umax(umax(SU_C, WP_C), umax(umax(HOLD_C, ACC_C), DB_C));
  localparam int          PH_W   = $clog2(PH_MAX + 1);
  localparam int          TO_W   = $clog2(TO_C + 1);
  localparam int          WL_W   = $clog2(WP_C + 2);

  localparam logic [PH_W-1:0] SU_V   = PH_W'(SU_C - 1);
  localparam logic [PH_W-1:0] WP_V   = PH_W'(WP_C - 1);
  localparam logic [PH_W-1:0] HOLD_V = PH_W'(HOLD_C - 1);
  localparam logic [PH_W-1:0] ACC_V  = PH_W'(ACC_C - 1);
  localparam logic [PH_W-1:0] DB_V   = PH_W'(DB_C - 1);
  localparam logic [TO_W-1:0] TO_V   = TO_W'(TO_C - 1);

  seq_state_t      state, nxt;
  logic [AW-1:0]   a_q;
  logic [DW-1:0]   d_q, rdat_q;
  logic            mode_q, hit_q, err_q;
  logic            ph_load, ph_zero, to_load, to_zero;
  logic [PH_W-1:0] ph_val;
  logic            top_hit, all_hit;

  nvm_cnt #(.W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
  );

  nvm_cnt #(.W(TO_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .load(to_load), .load_val(TO_V), .zero(to_zero)
  );

  nvm_poll_cmp #(.DW(DW)) u_cmp (
    .sample(mem_dq_in), .written(d_q), .top_hit(top_hit), .all_hit(all_hit)
  );

  // request gate: ready/busy mode also waits for the line to release
  assign req_ready = (state == ST_IDLE) && (!wait_mode || mem_rdy_n);

  always_comb begin
    nxt     = state;
    ph_load = 1'b0;
    ph_val  = '0;
    to_load = 1'b0;
    case (state)
      ST_IDLE: begin
        if (req_valid && req_ready) begin
          ph_load = 1'b1;
          if (req_write) begin
            nxt    = ST_WSETUP;
            ph_val = SU_V;
          end else begin
            nxt    = ST_RREAD;
            ph_val = ACC_V;
          end
        end
      end
      ST_WSETUP: if (ph_zero) begin nxt = ST_WPULSE; ph_load = 1'b1; ph_val = WP_V; end
      ST_WPULSE: if (ph_zero) begin nxt = ST_WHOLD; ph_load = 1'b1; ph_val = HOLD_V; end
      ST_WHOLD:  if (ph_zero) begin nxt = ST_TURN; to_load = 1'b1; end
      ST_TURN: begin
        ph_load = 1'b1;
        if (mode_q) begin
          nxt    = ST_RBDLY;
          ph_val = DB_V;
        end else begin
          nxt    = ST_PREAD;
          ph_val = ACC_V;
        end
      end
      ST_PREAD: if (ph_zero) nxt = ST_PGAP;
      ST_PGAP: begin
        if (hit_q) begin
          nxt = ST_CREAD; ph_load = 1'b1; ph_val = ACC_V;
        end else if (to_zero) begin
          nxt = ST_RESP;
        end else begin
          nxt = ST_PREAD; ph_load = 1'b1; ph_val = ACC_V;
        end
      end
      ST_RBDLY: begin
        if (to_zero)      nxt = ST_RESP;
        else if (ph_zero) nxt = ST_RBWAIT;
      end
      ST_RBWAIT: begin
        if (mem_rdy_n) begin
          nxt = ST_CREAD; ph_load = 1'b1; ph_val = ACC_V;
        end else if (to_zero) begin
          nxt = ST_RESP;
        end
      end
      ST_CREAD, ST_RREAD: if (ph_zero) nxt = ST_RESP;
      ST_RESP: if (rsp_ready) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      a_q    <= '0;
      d_q    <= '0;
      mode_q <= 1'b0;
      hit_q  <= 1'b0;
      rdat_q <= '0;
      err_q  <= 1'b0;
    end else begin
      state <= nxt;
      case (state)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            a_q    <= req_addr;
            d_q    <= req_data;
            mode_q <= wait_mode;
            hit_q  <= 1'b0;
            err_q  <= 1'b0;
          end
        end
        ST_PREAD: begin
          if (ph_zero) begin
            hit_q  <= top_hit;
            rdat_q <= mem_dq_in;
          end
        end
        ST_PGAP, ST_RBDLY, ST_RBWAIT: begin
          if (nxt == ST_RESP) err_q <= 1'b1;
        end
        ST_CREAD: begin
          if (ph_zero) begin
            rdat_q <= mem_dq_in;
            err_q  <= !all_hit;
          end
        end
        ST_RREAD: begin
          if (ph_zero) begin
            rdat_q <= mem_dq_in;
            err_q  <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  // strobes decoded from the single state register
  assign mem_ce_n   = !(state inside {ST_WSETUP, ST_WPULSE, ST_WHOLD, ST_PREAD, ST_CREAD, ST_RREAD});
  assign mem_oe_n   = !(state inside {ST_PREAD, ST_CREAD, ST_RREAD});
  assign mem_we_n   = (state != ST_WPULSE);
  assign mem_dq_oe  = (state inside {ST_WSETUP, ST_WPULSE, ST_WHOLD});
  assign mem_addr   = a_q;
  assign mem_dq_out = d_q;
  assign rsp_valid  = (state == ST_RESP);
  assign rsp_data   = rdat_q;
  assign rsp_err    = err_q;

  // length of the current write-enable low pulse, for the width check
  logic [WL_W-1:0] we_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        we_len <= '0;
    else if (!mem_we_n) we_len <= we_len + 1'b1;
    else               we_len <= '0;
  end

  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_len == WL_W'(WP_C)));

  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_out) && mem_dq_oe));

  assert_no_write_in_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n) |-> (mem_oe_n && !mem_ce_n));

  assert_bus_free_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n) |-> (!mem_dq_oe && !$past(mem_dq_oe)));

  assert_rsp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err)));

  assert_one_outstanding_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

endmodule

// File: tb/nvm_byte_ctrl_tb.sv
module nvm_byte_ctrl_tb;

  localparam int SU_E   = 2;
  localparam int WP_E   = 15;
  localparam int HOLD_E = 2;
  localparam int ACC_E  = 20;
  localparam int TO_E   = 400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wait_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [10:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic        rsp_ready = 1'b0;
  logic        req_ready, rsp_valid, rsp_err;
  logic [7:0]  rsp_data;
  logic [10:0] mem_addr;
  logic [7:0]  mem_dq_out, mem_dq_in;
  logic        mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n, mem_rdy_n;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nvm_byte_ctrl #(.T_WC_MAX_NS(4000)) u_dut (
    .clk(clk), .rst_n(rst_n), .wait_mode(wait_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_rdy_n(mem_rdy_n)
  );

  task automatic chk(input string tag, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] init_byte(input int i);
    return 8'((i * 7) + (i >> 3));
  endfunction

  // behavioural memory
  logic [7:0]  mdl_mem [0:2047];
  int          mdl_busy;
  logic [10:0] mdl_last_a;
  logic [7:0]  mdl_last_d;
  logic        mdl_p_we;
  int          busy_len = 40;
  logic [7:0]  corrupt = 8'h00;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2048; i++) mdl_mem[i] <= init_byte(i);
      mdl_busy   <= 0;
      mdl_last_a <= '0;
      mdl_last_d <= '0;
      mdl_p_we   <= 1'b1;
    end else begin
      mdl_p_we <= mem_we_n;
      if (!mdl_p_we && mem_we_n && !mem_ce_n) begin
        mdl_busy   <= busy_len;
        mdl_last_a <= mem_addr;
        mdl_last_d <= mem_dq_out;
      end else if (mdl_busy != 0) begin
        mdl_busy <= mdl_busy - 1;
        if (mdl_busy == 1) mdl_mem[mdl_last_a] <= mdl_last_d ^ corrupt;
      end
    end
  end

  assign mem_rdy_n = (mdl_busy == 0);
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ?
                     ((mdl_busy != 0 && mem_addr == mdl_last_a) ? {~mdl_last_d[7], 7'h2A}
                                                                : mdl_mem[mem_addr])
                     : 8'h00;

  // bus monitor, sampled away from the active edge
  logic [10:0] exp_addr = '0;
  logic [7:0]  exp_data = '0;
  logic p_we = 1'b1, p_oe = 1'b1, p_dqoe = 1'b0, p_rd = 1'b0;
  int   su_n = 0, we_cnt = 0, hold_n = 0, rd_n = 0, rd_win = 0;
  bit   in_hold = 1'b0, mon_rb = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_we_n && !mem_oe_n) chk("R11 we low during read", 1'b0, 1, 0);
      if (mem_dq_oe && !mem_oe_n) chk("R5 bus driven in read", 1'b0, 1, 0);
      if (!mem_oe_n && p_oe && p_dqoe) chk("R5 no turnaround", 1'b0, 1, 0);
      if (!mem_we_n) begin
        if (p_we) chk("R3 setup cycles", su_n == SU_E, su_n, SU_E);
        we_cnt++;
        chk("R3 addr during pulse", mem_addr == exp_addr, mem_addr, exp_addr);
        chk("R3 data during pulse", mem_dq_out == exp_data && mem_dq_oe, mem_dq_out, exp_data);
      end else if (!p_we) begin
        chk("R3 pulse width", we_cnt == WP_E, we_cnt, WP_E);
        we_cnt  = 0;
        in_hold = 1'b1;
        hold_n  = 0;
      end
      if (in_hold) begin
        if (mem_dq_oe) begin
          hold_n++;
          chk("R4 hold values", mem_addr == exp_addr && mem_dq_out == exp_data && mem_oe_n,
              mem_dq_out, exp_data);
        end else begin
          chk("R4 hold cycles", hold_n == HOLD_E, hold_n, HOLD_E);
          in_hold = 1'b0;
        end
      end
      if (!mem_ce_n && mem_we_n && mem_dq_oe && !in_hold) su_n++;
      else if (mem_ce_n) su_n = 0;
      if (!mem_ce_n && !mem_oe_n) begin
        rd_n++;
        if (mon_rb && !mem_rdy_n) chk("R8 read while busy", 1'b0, 1, 0);
      end else if (p_rd) begin
        chk("R6 read window", rd_n == ACC_E, rd_n, ACC_E);
        rd_win++;
        rd_n = 0;
      end
      p_we   = mem_we_n;
      p_oe   = mem_oe_n;
      p_dqoe = mem_dq_oe;
      p_rd   = !mem_ce_n && !mem_oe_n;
    end
  end

  task automatic xfer(input bit wr, input logic [10:0] a, input logic [7:0] d, input int bp,
                      output logic [7:0] rd, output logic re, output int dur);
    int t0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    exp_addr  = a;
    exp_data  = d;
    rd_win    = 0;
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_data  = d;
    t0 = cyc;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    dur = cyc - t0;
    rd  = rsp_data;
    re  = rsp_err;
    for (int i = 0; i < bp; i++) begin
      chk("R2 response held", rsp_valid && rsp_data == rd && rsp_err == re, rsp_data, rd);
      chk("R2 no ready while responding", !req_ready, req_ready, 0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic wait_idle_mem();
    while (mdl_busy != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog", 1'b0, cyc, 150000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0]  rd, expv;
    logic        re;
    logic [10:0] a;
    logic [7:0]  d;
    int          dur;
    int          seed;
    seed = $urandom(32'h5EED1234);

    repeat (3) @(negedge clk);
    chk("R1 strobes in reset", mem_ce_n && mem_oe_n && mem_we_n, {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    chk("R1 bus released in reset", !mem_dq_oe && !rsp_valid, {mem_dq_oe, rsp_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 ready after reset", req_ready, req_ready, 1);

    // reads: boundary addresses then random
    for (int i = 0; i < 10; i++) begin
      a = (i == 0) ? 11'd0 : (i == 1) ? 11'd2047 : 11'($urandom);
      expv = mdl_mem[a];
      xfer(1'b0, a, 8'h00, (i == 2) ? 5 : 0, rd, re, dur);
      chk("R6 read data", rd == expv, rd, expv);
      chk("R6 read err", re == 1'b0, re, 0);
    end

    // polling writes, both bit-7 polarities directed first
    wait_mode = 1'b0;
    for (int i = 0; i < 10; i++) begin
      a = 11'($urandom);
      d = (i == 0) ? 8'h80 : (i == 1) ? 8'h7F : 8'($urandom);
      busy_len = 30 + int'($urandom % 250);
      xfer(1'b1, a, d, (i == 3) ? 3 : 0, rd, re, dur);
      chk("R10 confirm data", rd == d, rd, d);
      chk("R10 confirm err", re == 1'b0, re, 0);
      chk("R7 polled before confirm", rd_win >= 2, rd_win, 2);
      wait_idle_mem();
      xfer(1'b0, a, 8'h00, 0, rd, re, dur);
      chk("R10 readback", rd == d, rd, d);
    end

    // ready/busy writes
    wait_mode = 1'b1;
    for (int i = 0; i < 6; i++) begin
      a = 11'($urandom);
      d = 8'($urandom);
      busy_len = 30 + int'($urandom % 250);
      mon_rb = 1'b1;
      xfer(1'b1, a, d, 0, rd, re, dur);
      mon_rb = 1'b0;
      chk("R8 single confirm read", rd_win == 1, rd_win, 1);
      chk("R10 confirm data rb", rd == d && re == 1'b0, rd, d);
    end

    // confirm mismatch: stored byte differs in bit 0 only
    wait_mode = 1'b0;
    corrupt   = 8'h01;
    busy_len  = 50;
    d = 8'hC5;
    xfer(1'b1, 11'h155, d, 0, rd, re, dur);
    chk("R10 mismatch err", re == 1'b1, re, 1);
    chk("R10 mismatch data", rd == (d ^ 8'h01), rd, d ^ 8'h01);
    corrupt = 8'h00;
    wait_idle_mem();

    // timeout in polling mode
    busy_len = 1000;
    xfer(1'b1, 11'h2AA, 8'h3C, 0, rd, re, dur);
    chk("R9 poll timeout err", re == 1'b1, re, 1);
    chk("R9 poll timeout not early", dur >= TO_E, dur, TO_E);
    wait_idle_mem();

    // timeout in ready/busy mode
    wait_mode = 1'b1;
    mon_rb    = 1'b1;
    xfer(1'b1, 11'h0F0, 8'hA5, 0, rd, re, dur);
    mon_rb = 1'b0;
    chk("R9 rb timeout err", re == 1'b1, re, 1);
    chk("R9 rb timeout no confirm", rd_win == 0, rd_win, 0);
    chk("R9 rb timeout not early", dur >= TO_E, dur, TO_E);
    @(negedge clk);
    chk("R8 refuse while busy", !req_ready && !mem_rdy_n, req_ready, 0);
    wait_idle_mem();
    chk("R8 ready after release", req_ready, req_ready, 1);
    wait_mode = 1'b0;
    busy_len  = 40;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule